// File: doc/BRIEF.md
# GPIO Bank with Edge/Level Interrupts

This block controls one bank of general-purpose pins over a small 32-bit register bus. Software makes pins outputs or inputs, drives the output latch and programs interrupt behaviour. None of these vectors is ever written whole. Every change goes through a write-one-to-set register or a write-one-to-clear register, so one pin can be changed without reading the vector and writing it back.

Only the lowest eight pins can raise an interrupt. A single 32-bit control word holds four per-pin fields:

- a rising enable,
- a falling enable,
- a stored-only debounce enable,
- a mode selector that picks level or edge.

In level mode the rising enable means "interrupt while high" and the falling enable means "interrupt while low". Edge events are held in sticky status bits that software acknowledges. Level status follows the pin while the condition lasts. All status bits are ORed into one registered interrupt line.

The request channel is valid/ready. `bus_ready` is always high, so a request is accepted in every cycle that `bus_valid` is high, and there is never back-pressure. A read returns its data one clock after acceptance, with `rsp_valid` high for one cycle. The response channel takes no back-pressure. Writes give no response.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset, all pins are inputs (`pin_oe` is 0). The output latch, the interrupt-control word, all status bits and `irq` are 0.
- R2: Writing word index 1 (byte 0x04) sets the output-enable bits written as 1. Writing index 2 (0x08) clears them. Bits written as 0 keep their value. Indices 0, 1 and 2 read the output-enable vector, which drives `pin_oe`.
- R3: Writing index 4 (0x10) sets output-latch bits and index 5 (0x14) clears them, again only for bits written as 1. Reading 0x10 returns the latch, which drives `pin_out`.
- R4: Reading index 3 (0x0C) returns `pin_in` after a two-flop synchronizer.
- R5: In edge mode (control bit 24+i clear), a rising transition of pin i (i < 8) with rise bit i set latches status bit i. Status is read at index 9 (0x24).
- R6: In edge mode, fall bit 8+i latches status on a falling transition. With both bits set, either transition latches status.
- R7: With level bit 24+i set, status bit i is 1 while the pin is high (rise bit set) or low (fall bit set). It is not latched, and an acknowledge does not hold it low while the condition remains.
- R8: Writing 1s to index 8 (0x20) clears the matching latched edge status bits. Other status bits are unchanged.
- R9: A pin whose rise and fall bits are both clear shows no status, including an edge latched before it was masked.
- R10: Pins 8 to 31 never raise status. Status bits 31:8 read as 0.
- R11: `irq` equals the OR of all status bits one clock earlier.
- R12: Control bits 23:16 (debounce enables) are stored and read back at indices 6 and 7 (0x18, 0x1C). Index 6 sets control bits and index 7 clears them.
- R13: `bus_ready` is high. `rsp_valid` is high exactly in the cycle after an accepted read, and is low after writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request ready (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits 5:2 pick the register |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
Some rules are checked by the assertions on every cycle:

- the set and clear effects on `pin_oe` and `pin_out`,
- the read-response timing,
- `irq` trailing the OR of status by one clock,
- masked pins staying silent,
- the upper status bits of every status read being zero.

Other behaviour only the bench scenarios can show. These are edge capture across the synchronizer delay, an acknowledge that clears one bit and leaves another, a level status that survives an acknowledge, and the stored debounce field.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // Register word indices (byte address / 4)
  localparam int unsigned IDX_OE_RD   = 0;
  localparam int unsigned IDX_OE_SET  = 1;
  localparam int unsigned IDX_OE_CLR  = 2;
  localparam int unsigned IDX_PIN_RD  = 3;
  localparam int unsigned IDX_OUT_SET = 4;
  localparam int unsigned IDX_OUT_CLR = 5;
  localparam int unsigned IDX_CTL_SET = 6;
  localparam int unsigned IDX_CTL_CLR = 7;
  localparam int unsigned IDX_ACK     = 8;
  localparam int unsigned IDX_STAT    = 9;
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (set_en) q <= q | bits;
    else if (clr_en) q <= q & ~bits;
  end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] now_q,
  output logic [W-1:0] prev_q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      now_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      now_q  <= meta_q;
      prev_q <= now_q;
    end
  end
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_now,
  input  logic pin_prev,
  input  logic rise_en,
  input  logic fall_en,
  input  logic level_mode,
  input  logic ack,
  output logic status
);
  logic sticky_q;
  logic armed;
  logic edge_hit;
  logic level_hit;

  assign armed     = rise_en | fall_en;
  assign edge_hit  = !level_mode && ((rise_en && pin_now && !pin_prev) ||
                                     (fall_en && !pin_now && pin_prev));
  assign level_hit = level_mode && ((rise_en && pin_now) || (fall_en && !pin_now));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     sticky_q <= 1'b0;
    else if (level_mode || !armed)  sticky_q <= 1'b0;
    else if (edge_hit)              sticky_q <= 1'b1;
    else if (ack)                   sticky_q <= 1'b0;
  end

  assign status = (sticky_q && armed && !level_mode) || level_hit;
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int NPINS  = 32,
  parameter int NIRQ   = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  import gpio_bank_pkg::*;

  localparam int IDX_W    = ADDR_W - 2;
  localparam int RISE_LSB = 0;
  localparam int FALL_LSB = NIRQ;
  localparam int LVL_LSB  = 3 * NIRQ;

  logic [IDX_W-1:0]  word;
  logic              wr_go, rd_go;
  logic [DATA_W-1:0] ctl_q;
  logic [NPINS-1:0]  oe_q, out_q, pin_now, pin_prev;
  logic [NIRQ-1:0]   irq_status;
  logic [DATA_W-1:0] rd_mux;
  logic              irq_q;

  function automatic logic hit(input logic [IDX_W-1:0] w, input int unsigned idx);
    return w == IDX_W'(idx);
  endfunction

  assign bus_ready = 1'b1;
  assign word      = bus_addr[ADDR_W-1:2];
  assign wr_go     = bus_valid && bus_ready && bus_write;
  assign rd_go     = bus_valid && bus_ready && !bus_write;

  gpio_setclr_reg #(.W(NPINS)) u_oe (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr_go && hit(word, IDX_OE_SET)),
    .clr_en(wr_go && hit(word, IDX_OE_CLR)),
    .bits(bus_wdata[NPINS-1:0]), .q(oe_q));

  gpio_setclr_reg #(.W(NPINS)) u_out (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr_go && hit(word, IDX_OUT_SET)),
    .clr_en(wr_go && hit(word, IDX_OUT_CLR)),
    .bits(bus_wdata[NPINS-1:0]), .q(out_q));

  gpio_setclr_reg #(.W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr_go && hit(word, IDX_CTL_SET)),
    .clr_en(wr_go && hit(word, IDX_CTL_CLR)),
    .bits(bus_wdata), .q(ctl_q));

  gpio_pin_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in),
    .now_q(pin_now), .prev_q(pin_prev));

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    gpio_irq_pin u_pin (
      .clk(clk), .rst_n(rst_n),
      .pin_now(pin_now[i]), .pin_prev(pin_prev[i]),
      .rise_en(ctl_q[RISE_LSB+i]), .fall_en(ctl_q[FALL_LSB+i]),
      .level_mode(ctl_q[LVL_LSB+i]),
      .ack(wr_go && hit(word, IDX_ACK) && bus_wdata[i]),
      .status(irq_status[i]));
  end

  always_comb begin
    rd_mux = '0;
    if (hit(word, IDX_OE_RD) || hit(word, IDX_OE_SET) || hit(word, IDX_OE_CLR))
      rd_mux[NPINS-1:0] = oe_q;
    else if (hit(word, IDX_PIN_RD))
      rd_mux[NPINS-1:0] = pin_now;
    else if (hit(word, IDX_OUT_SET) || hit(word, IDX_OUT_CLR))
      rd_mux[NPINS-1:0] = out_q;
    else if (hit(word, IDX_CTL_SET) || hit(word, IDX_CTL_CLR))
      rd_mux = ctl_q;
    else if (hit(word, IDX_STAT))
      rd_mux[NIRQ-1:0] = irq_status;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      irq_q     <= 1'b0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) rsp_data <= rd_mux;
      irq_q     <= |irq_status;
    end
  end

  assign pin_oe  = oe_q;
  assign pin_out = out_q;
  assign irq     = irq_q;
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk #(
  parameter int NPINS  = 32,
  parameter int NIRQ   = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [DATA_W-1:0] ctl_q,
  input logic [NIRQ-1:0]   irq_status
);
  logic wr;
  assign wr = bus_valid && bus_ready && bus_write;

  // R2
  assert_oe_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 6'h04) |=> ((pin_oe & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));
  assert_oe_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 6'h08) |=> ((pin_oe & $past(bus_wdata[NPINS-1:0])) == '0));
  // R3
  assert_out_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 6'h10) |=> ((pin_out & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));
  assert_out_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 6'h14) |=> ((pin_out & $past(bus_wdata[NPINS-1:0])) == '0));
  // R10
  assert_stat_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !bus_write && bus_addr == 6'h24) |=> (rsp_data[DATA_W-1:NIRQ] == '0));
  // R11
  assert_irq_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|irq_status)));
  // R13
  assert_rsp_timing_R13: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rsp_valid == $past(bus_valid && bus_ready && !bus_write)));

  for (genvar i = 0; i < NIRQ; i++) begin : g_mask
    // R9
    assert_masked_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q[i] && !ctl_q[NIRQ+i]) |-> !irq_status[i]);
  end
endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(
  .NPINS(NPINS), .NIRQ(NIRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pin_out(pin_out),
  .pin_oe(pin_oe), .irq(irq), .ctl_q(ctl_q), .irq_status(irq_status)
);

// File: tb/sim_gpio_bank_irq.sv
`timescale 1ns/1ps
module sim_gpio_bank_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [31:0] pins = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank_irq u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pin_in(pins),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  typedef struct packed {
    logic        rd;
    logic [5:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h04, 32'h0000_00F0},  // R2 set
    '{1'b1, 6'h00, 32'h0000_00F0},
    '{1'b0, 6'h08, 32'h0000_0030},  // R2 clear
    '{1'b1, 6'h04, 32'h0000_00C0},
    '{1'b0, 6'h10, 32'hA5A5_0000},  // R3 set
    '{1'b1, 6'h10, 32'hA5A5_0000},
    '{1'b0, 6'h14, 32'h0005_0000},  // R3 clear
    '{1'b1, 6'h10, 32'hA5A0_0000},
    '{1'b0, 6'h18, 32'h00FF_0000},  // R12 debounce set
    '{1'b1, 6'h18, 32'h00FF_0000},
    '{1'b0, 6'h1C, 32'h000F_0000},  // R12 partial clear
    '{1'b1, 6'h1C, 32'h00F0_0000},
    '{1'b0, 6'h1C, 32'h00F0_0000},  // R12 clear rest
    '{1'b1, 6'h18, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    check("R13 no response after write", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = rsp_data;
    check("R13 read response valid", {31'd0, rsp_valid}, 32'd1);
    bus_valid = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check("R1 pin_oe", pin_oe, 32'd0);
    check("R1 pin_out", pin_out, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R13 bus_ready", {31'd0, bus_ready}, 32'd1);
    rd_chk("R1 ctl", 6'h18, 32'd0);
    rd_chk("R1 status", 6'h24, 32'd0);

    for (int k = 0; k < NV; k++) begin
      if (VECS[k].rd) rd_chk($sformatf("table %0d (R2/R3/R12)", k), VECS[k].addr, VECS[k].data);
      else            wr(VECS[k].addr, VECS[k].data);
    end
    check("R2 pin_oe port", pin_oe, 32'h0000_00C0);
    check("R3 pin_out port", pin_out, 32'hA5A0_0000);

    // R4 synchronized pin read
    pins = 32'h1234_5678; idle(4);
    rd_chk("R4 pin value", 6'h0C, 32'h1234_5678);
    pins = '0; idle(4);

    // R5 rising edge on pin0
    wr(6'h18, 32'h0000_0001);
    pins[0] = 1'b1; idle(5);
    rd_chk("R5 rise latched", 6'h24, 32'h1);
    check("R11 irq high", {31'd0, irq}, 32'd1);
    pins[0] = 1'b0; idle(5);
    rd_chk("R5 fall ignored, sticky", 6'h24, 32'h1);
    wr(6'h20, 32'h1);
    rd_chk("R8 ack clears", 6'h24, 32'h0);
    idle(2);
    check("R11 irq low after ack", {31'd0, irq}, 32'd0);

    // R9 masked pin
    wr(6'h1C, 32'h0000_0001);
    pins[0] = 1'b1; idle(5);
    rd_chk("R9 masked no status", 6'h24, 32'h0);
    check("R9 irq low", {31'd0, irq}, 32'd0);
    pins[0] = 1'b0; idle(4);

    // R6 falling edge pin1, both edges pin2
    wr(6'h18, 32'h0000_0200);
    pins[1] = 1'b1; idle(5);
    rd_chk("R6 rise ignored", 6'h24, 32'h0);
    pins[1] = 1'b0; idle(5);
    rd_chk("R6 fall latched", 6'h24, 32'h2);
    wr(6'h18, 32'h0000_0404);
    pins[2] = 1'b1; idle(5);
    rd_chk("R6 both rise", 6'h24, 32'h6);
    wr(6'h20, 32'h2);
    rd_chk("R8 partial ack", 6'h24, 32'h4);
    wr(6'h20, 32'h4);
    rd_chk("R8 ack rest", 6'h24, 32'h0);
    pins[2] = 1'b0; idle(5);
    rd_chk("R6 both fall", 6'h24, 32'h4);
    wr(6'h20, 32'h4);
    rd_chk("R8 ack pin2", 6'h24, 32'h0);

    // R7 level high pin3, level low pin4
    wr(6'h18, 32'h0800_0008);
    pins[3] = 1'b1; idle(4);
    rd_chk("R7 level high", 6'h24, 32'h8);
    wr(6'h20, 32'h8);
    rd_chk("R7 ack no effect", 6'h24, 32'h8);
    pins[3] = 1'b0; idle(4);
    rd_chk("R7 level gone", 6'h24, 32'h0);
    wr(6'h18, 32'h1000_1000);
    idle(2);
    rd_chk("R7 level low", 6'h24, 32'h10);
    pins[4] = 1'b1; idle(4);
    rd_chk("R7 level low gone", 6'h24, 32'h0);

    // R9 masking a pending edge
    wr(6'h18, 32'h0000_0020);
    pins[5] = 1'b1; idle(5);
    rd_chk("R5 pin5 latched", 6'h24, 32'h20);
    wr(6'h1C, 32'h0000_0020);
    rd_chk("R9 pending masked", 6'h24, 32'h0);
    idle(2);
    check("R9 irq low", {31'd0, irq}, 32'd0);

    // R10 upper pins never interrupt
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h18, 32'h0000_FFFF);
    pins = pins ^ 32'hFFFF_FF00; idle(5);
    rd_chk("R10 upper toggle", 6'h24, 32'h0);
    pins = pins ^ 32'hFFFF_FF00; idle(5);
    rd_chk("R10 upper toggle back", 6'h24, 32'h0);
    check("R10 irq low", {31'd0, irq}, 32'd0);

    summary();
  end
endmodule